// File: doc/BRIEF.md
# Wide Register Write Collector

This block turns a stream of 32-bit host write beats into atomic wide writes. Internal control registers are 128 bits wide and internal SRAM words are 64 bits wide, so the host writes them one dword at a time. The block gathers those dwords in a single shared collector and issues one wide write, with the full data and the aligned target address, once every part of the target has arrived. Plain 32-bit registers bypass the collector and go out on a narrow write port.

Two register pairs in every 0x2000-byte page are descriptor pointers. Their offsets within the page are 0x830 and 0xA10. A write to the top dword of one of them (0x83C or 0xA1C) always commits that register at once. Any of the three lower dwords that the collector does not hold for that register are written as zero. A lower-dword write to one of them is dropped while the collector holds another target. A dword write to offset 0x420 of page 0 empties the collector, and any partly gathered write is lost.

The host side carries only a valid qualifier. The block accepts one beat on every clock edge where `host_valid` is high and never applies back-pressure, so it has no ready output. Each write port raises a one-cycle strobe on the clock edge after the beat that caused it. Downstream logic must take the write on that cycle.

Top module: `wide_write_collector`

## Requirements
- R1: A normal 128-bit register commits on `reg_wr_en` only once all four of its dwords have arrived, in any order. Dword k, at byte address base+4k, lands in `reg_wr_data[32k+31:32k]`, and `reg_wr_addr` is the 16-byte aligned base.
- R2: A second write to a dword already held for the same target replaces the held value and does not count towards completion.
- R3: A dword write to a different normal wide register while the collector is busy discards the partial data held. Collection then restarts with that dword.
- R4: Addresses at or above `SRAM_BASE` are SRAM. The word index is (addr − `SRAM_BASE`)/8. The dword with address bit 2 set fills `sram_wr_data[63:32]`. The word commits on `sram_wr_en` once both dwords have arrived.
- R5: A write to page offset 0x83C or 0xA1C commits the register at page offset 0x830 or 0xA10 with the new top dword. Each lower dword comes from the collector if the collector holds it for that register, and is zero otherwise.
- R6: A write to page offset 0x830–0x838 or 0xA10–0xA18 is dropped when the collector holds a different target. The collector keeps its contents.
- R7: A write to page offset 0x400 or 0x420 in any page is issued on `dw_wr_en` with its own address and data. It does not change the collector, except for the case in R8.
- R8: A write to byte address 0x420 (page 0) empties the collector as well as issuing the narrow write.
- R9: Every strobe is high for exactly one cycle, on the clock edge after the beat that caused it. At most one of `reg_wr_en` and `sram_wr_en` is high in any cycle. Reset drives all strobes low and empties the collector.
- R10: The descriptor-pointer handling applies in every page, because it decodes the offset within the page and ignores the page number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | A host write beat is present this cycle |
| host_addr | input | ADDR_W | Byte address of the dword written |
| host_data | input | 32 | Dword write data |
| reg_wr_en | output | 1 | One-cycle wide register write strobe |
| reg_wr_addr | output | ADDR_W | 16-byte aligned register address |
| reg_wr_data | output | 128 | Full register data |
| sram_wr_en | output | 1 | One-cycle SRAM word write strobe |
| sram_wr_idx | output | ADDR_W-3 | SRAM word index |
| sram_wr_data | output | 64 | Full SRAM word data |
| dw_wr_en | output | 1 | One-cycle 32-bit register write strobe |
| dw_wr_addr | output | ADDR_W | Byte address of the 32-bit register |
| dw_wr_data | output | 32 | 32-bit register data |

## Verification
The bench replays interleaved write sequences and compares every port against the writes it expects. The sequences cover out-of-order dwords, a rewritten dword, a switch of target partway through a register, and SRAM words filled high dword first. A design without zero fill would let stale lanes leak into a descriptor-pointer commit. A design that restarts on stray lower-dword writes would lose the normal register being gathered around them. A design that clears the collector on offset 0x420 in a page other than page 0 would drop a write that should complete. Back-to-back beats and a reset in the middle of a collection check that the strobe comes one cycle after the last beat, stays high for that single cycle only, and that reset discards any gathered data.

// File: rtl/cw_pkg.sv
package cw_pkg;
  // word geometry
  localparam int WORD_W     = 32;
  localparam int LANES      = 4;
  localparam int SRAM_LANES = 2;
  localparam int WIDE_W     = WORD_W * LANES;
  localparam int SRAM_W     = WORD_W * SRAM_LANES;
  localparam int LANE_IDX_W = $clog2(LANES);

  // paged layout: offsets inside one page
  localparam int PAGE_SHIFT   = 13;
  localparam int OFF_PTR_A    = 'h830;
  localparam int OFF_PTR_B    = 'hA10;
  localparam int OFF_SINGLE_A = 'h400;
  localparam int OFF_SINGLE_B = 'h420;

  typedef enum logic [2:0] {
    AC_WIDE     = 3'd0,  // normal 128-bit register dword
    AC_SPEC_LO  = 3'd1,  // lower dword of a descriptor pointer
    AC_SPEC_TOP = 3'd2,  // top dword of a descriptor pointer
    AC_SINGLE   = 3'd3,  // plain 32-bit register
    AC_SRAM     = 3'd4   // SRAM dword
  } acc_kind_e;
endpackage

// File: rtl/cw_decode.sv
module cw_decode
  import cw_pkg::*;
#(
  parameter int          ADDR_W    = 20,
  parameter int unsigned SRAM_BASE = 'h80000
) (
  input  logic [ADDR_W-1:0]     addr,
  output acc_kind_e             kind,
  output logic [ADDR_W-1:0]     tgt,
  output logic [LANE_IDX_W-1:0] lane,
  output logic                  clr
);
  localparam int OFF_W = PAGE_SHIFT;

  logic [OFF_W-1:0] off;
  logic             in_sram;
  logic             page_zero;
  logic             is_single;
  logic             is_ptr;
  logic             is_top;

  always_comb begin
    off       = addr[OFF_W-1:0];
    in_sram   = addr >= ADDR_W'(SRAM_BASE);
    page_zero = addr[ADDR_W-1:OFF_W] == '0;
    is_single = (off == OFF_W'(OFF_SINGLE_A)) || (off == OFF_W'(OFF_SINGLE_B));
    is_ptr    = (off[OFF_W-1:4] == (OFF_W-4)'(OFF_PTR_A >> 4)) ||
                (off[OFF_W-1:4] == (OFF_W-4)'(OFF_PTR_B >> 4));
    is_top    = off[3:2] == 2'b11;
  end

  always_comb begin
    clr = 1'b0;
    if (in_sram) begin
      kind = AC_SRAM;
      tgt  = {addr[ADDR_W-1:3], 3'b000};
      lane = {1'b0, addr[2]};
    end else begin
      tgt  = {addr[ADDR_W-1:4], 4'b0000};
      lane = addr[3:2];
      if (is_single) begin
        kind = AC_SINGLE;
        clr  = page_zero && (off == OFF_W'(OFF_SINGLE_B));
      end else if (is_ptr) begin
        kind = is_top ? AC_SPEC_TOP : AC_SPEC_LO;
      end else begin
        kind = AC_WIDE;
      end
    end
  end
endmodule

// File: rtl/cw_collect.sv
module cw_collect
  import cw_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [WORD_W-1:0]     in_data,
  input  acc_kind_e             in_kind,
  input  logic [ADDR_W-1:0]     in_tgt,
  input  logic [LANE_IDX_W-1:0] in_lane,
  input  logic                  in_clr,
  output logic                  cm_wide,
  output logic                  cm_sram,
  output logic                  cm_dw,
  output logic [ADDR_W-1:0]     cm_addr,
  output logic [WIDE_W-1:0]     cm_data
);
  localparam logic [LANES-1:0] FULL_WIDE = '1;
  localparam logic [LANES-1:0] FULL_SRAM = LANES'((1 << SRAM_LANES) - 1);

  logic              busy_q, n_busy;
  logic              sram_q, n_sram;
  logic [ADDR_W-1:0] addr_q, n_addr;
  logic [LANES-1:0]  mask_q, n_mask;
  logic [WORD_W-1:0] data_q [LANES];

  logic              hit;
  logic              store;
  logic              use_zero;
  logic [LANES-1:0]  lane_sel;
  logic [LANES-1:0]  merged_mask;
  logic [LANES-1:0]  full_mask;
  logic [WIDE_W-1:0] merged_flat;
  logic [WIDE_W-1:0] zero_flat;

  assign hit         = busy_q && (sram_q == (in_kind == AC_SRAM)) && (addr_q == in_tgt);
  assign lane_sel    = LANES'(1) << in_lane;
  assign merged_mask = (hit ? mask_q : '0) | lane_sel;
  assign full_mask   = (in_kind == AC_SRAM) ? FULL_SRAM : FULL_WIDE;

  // per-lane storage and the two commit views
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (store && lane_sel[i]) data_q[i] <= in_data;
    end
    assign merged_flat[i*WORD_W +: WORD_W] = lane_sel[i] ? in_data : data_q[i];
    if (i == LANES - 1) begin : g_top
      assign zero_flat[i*WORD_W +: WORD_W] = in_data;
    end else begin : g_low
      assign zero_flat[i*WORD_W +: WORD_W] = (hit && mask_q[i]) ? data_q[i] : '0;
    end
  end

  always_comb begin
    n_busy   = busy_q;
    n_sram   = sram_q;
    n_addr   = addr_q;
    n_mask   = mask_q;
    store    = 1'b0;
    use_zero = 1'b0;
    cm_wide  = 1'b0;
    cm_sram  = 1'b0;
    cm_dw    = 1'b0;
    if (in_valid) begin
      case (in_kind)
        AC_SINGLE: begin
          cm_dw = 1'b1;
          if (in_clr) begin
            n_busy = 1'b0;
            n_mask = '0;
          end
        end
        AC_SPEC_TOP: begin
          cm_wide  = 1'b1;
          use_zero = 1'b1;
          if (hit) begin
            n_busy = 1'b0;
            n_mask = '0;
          end
        end
        AC_SPEC_LO: begin
          if (!busy_q || hit) begin
            store  = 1'b1;
            n_busy = 1'b1;
            n_sram = 1'b0;
            n_addr = in_tgt;
            n_mask = merged_mask;
          end
        end
        default: begin // AC_WIDE, AC_SRAM
          if (merged_mask == full_mask) begin
            cm_wide = (in_kind != AC_SRAM);
            cm_sram = (in_kind == AC_SRAM);
            n_busy  = 1'b0;
            n_mask  = '0;
          end else begin
            store  = 1'b1;
            n_busy = 1'b1;
            n_sram = (in_kind == AC_SRAM);
            n_addr = in_tgt;
            n_mask = merged_mask;
          end
        end
      endcase
    end
  end

  assign cm_addr = in_tgt;
  assign cm_data = use_zero ? zero_flat : merged_flat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sram_q <= 1'b0;
      addr_q <= '0;
      mask_q <= '0;
    end else begin
      busy_q <= n_busy;
      sram_q <= n_sram;
      addr_q <= n_addr;
      mask_q <= n_mask;
    end
  end

  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind == AC_SINGLE && in_clr) |=> (!busy_q && mask_q == '0));

  assert_drop_keeps_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind == AC_SPEC_LO && busy_q && !hit) |=>
      ($stable(mask_q) && $stable(addr_q) && busy_q));

  assert_repeat_no_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind == AC_WIDE && hit && mask_q[in_lane]) |=>
      (mask_q == $past(mask_q)));

  assert_single_leaves_collector_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind == AC_SINGLE && !in_clr) |=>
      ($stable(mask_q) && $stable(busy_q)));
endmodule

// File: rtl/cw_out_stage.sv
module cw_out_stage
  import cw_pkg::*;
#(
  parameter int          ADDR_W    = 20,
  parameter int unsigned SRAM_BASE = 'h80000,
  localparam int         SIDX_W    = ADDR_W - 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cm_wide,
  input  logic              cm_sram,
  input  logic              cm_dw,
  input  logic [ADDR_W-1:0] cm_addr,
  input  logic [WIDE_W-1:0] cm_data,
  input  logic [ADDR_W-1:0] raw_addr,
  input  logic [WORD_W-1:0] raw_data,
  output logic              reg_wr_en,
  output logic [ADDR_W-1:0] reg_wr_addr,
  output logic [WIDE_W-1:0] reg_wr_data,
  output logic              sram_wr_en,
  output logic [SIDX_W-1:0] sram_wr_idx,
  output logic [SRAM_W-1:0] sram_wr_data,
  output logic              dw_wr_en,
  output logic [ADDR_W-1:0] dw_wr_addr,
  output logic [WORD_W-1:0] dw_wr_data
);
  logic [SIDX_W-1:0] idx_next;
  assign idx_next = SIDX_W'((cm_addr - ADDR_W'(SRAM_BASE)) >> 3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_wr_en  <= 1'b0;
      sram_wr_en <= 1'b0;
      dw_wr_en   <= 1'b0;
    end else begin
      reg_wr_en  <= cm_wide;
      sram_wr_en <= cm_sram;
      dw_wr_en   <= cm_dw;
    end
  end

  always_ff @(posedge clk) begin
    if (cm_wide) begin
      reg_wr_addr <= cm_addr;
      reg_wr_data <= cm_data;
    end
    if (cm_sram) begin
      sram_wr_idx  <= idx_next;
      sram_wr_data <= cm_data[SRAM_W-1:0];
    end
    if (cm_dw) begin
      dw_wr_addr <= raw_addr;
      dw_wr_data <= raw_data;
    end
  end

  assert_wide_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> (reg_wr_addr[3:0] == 4'b0000));

  assert_sram_has_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sram_wr_en |-> $past(cm_sram));
endmodule

// File: rtl/wide_write_collector.sv
module wide_write_collector
  import cw_pkg::*;
#(
  parameter int          ADDR_W    = 20,
  parameter int unsigned SRAM_BASE = 'h80000,
  localparam int         SIDX_W    = ADDR_W - 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_data,
  output logic              reg_wr_en,
  output logic [ADDR_W-1:0] reg_wr_addr,
  output logic [127:0]      reg_wr_data,
  output logic              sram_wr_en,
  output logic [SIDX_W-1:0] sram_wr_idx,
  output logic [63:0]       sram_wr_data,
  output logic              dw_wr_en,
  output logic [ADDR_W-1:0] dw_wr_addr,
  output logic [31:0]       dw_wr_data
);
  acc_kind_e             d_kind;
  logic [ADDR_W-1:0]     d_tgt;
  logic [LANE_IDX_W-1:0] d_lane;
  logic                  d_clr;

  logic                  c_wide, c_sram, c_dw;
  logic [ADDR_W-1:0]     c_addr;
  logic [WIDE_W-1:0]     c_data;

  cw_decode #(.ADDR_W(ADDR_W), .SRAM_BASE(SRAM_BASE)) u_decode (
    .addr (host_addr),
    .kind (d_kind),
    .tgt  (d_tgt),
    .lane (d_lane),
    .clr  (d_clr)
  );

  cw_collect #(.ADDR_W(ADDR_W)) u_collect (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (host_valid),
    .in_data  (host_data),
    .in_kind  (d_kind),
    .in_tgt   (d_tgt),
    .in_lane  (d_lane),
    .in_clr   (d_clr),
    .cm_wide  (c_wide),
    .cm_sram  (c_sram),
    .cm_dw    (c_dw),
    .cm_addr  (c_addr),
    .cm_data  (c_data)
  );

  cw_out_stage #(.ADDR_W(ADDR_W), .SRAM_BASE(SRAM_BASE)) u_out (
    .clk          (clk),
    .rst_n        (rst_n),
    .cm_wide      (c_wide),
    .cm_sram      (c_sram),
    .cm_dw        (c_dw),
    .cm_addr      (c_addr),
    .cm_data      (c_data),
    .raw_addr     (host_addr),
    .raw_data     (host_data),
    .reg_wr_en    (reg_wr_en),
    .reg_wr_addr  (reg_wr_addr),
    .reg_wr_data  (reg_wr_data),
    .sram_wr_en   (sram_wr_en),
    .sram_wr_idx  (sram_wr_idx),
    .sram_wr_data (sram_wr_data),
    .dw_wr_en     (dw_wr_en),
    .dw_wr_addr   (dw_wr_addr),
    .dw_wr_data   (dw_wr_data)
  );

  assert_top_dword_commits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && d_kind == AC_SPEC_TOP) |=> reg_wr_en);

  assert_single_commit_port_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && sram_wr_en));

  assert_narrow_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dw_wr_en |-> $past(host_valid));
endmodule

// File: tb/wide_write_collector_bench.sv
`timescale 1ns/1ps
module wide_write_collector_bench;
  localparam int ADDR_W = 20;
  localparam int SIDX_W = ADDR_W - 3;
  // entry: {req, addr, data, kind, exp_addr, exp_data}; kind 0 none, 1 wide, 2 sram, 3 narrow
  localparam int ENT_W = 4 + 20 + 32 + 2 + 20 + 128;
  localparam int NV    = 41;

  localparam logic [ENT_W-1:0] VEC [NV] = '{
    // R1/R2: normal register 0x100, out of order, dword1 rewritten
    {4'd1, 20'h00108, 32'h1111_0002, 2'd0, 20'h0, 128'h0},
    {4'd1, 20'h00100, 32'h1111_0000, 2'd0, 20'h0, 128'h0},
    {4'd1, 20'h00104, 32'h1111_0001, 2'd0, 20'h0, 128'h0},
    {4'd2, 20'h00104, 32'h2222_0001, 2'd0, 20'h0, 128'h0},
    {4'd2, 20'h0010C, 32'h1111_0003, 2'd1, 20'h00100,
      {32'h1111_0003, 32'h1111_0002, 32'h2222_0001, 32'h1111_0000}},
    // R3: switch target, then restart
    {4'd3, 20'h00200, 32'h3333_0000, 2'd0, 20'h0, 128'h0},
    {4'd3, 20'h00204, 32'h3333_0001, 2'd0, 20'h0, 128'h0},
    {4'd3, 20'h00300, 32'h4444_0000, 2'd0, 20'h0, 128'h0},
    {4'd3, 20'h00208, 32'h3333_0002, 2'd0, 20'h0, 128'h0},
    {4'd3, 20'h0020C, 32'h3333_0003, 2'd0, 20'h0, 128'h0},
    {4'd3, 20'h00200, 32'h5555_0000, 2'd0, 20'h0, 128'h0},
    {4'd3, 20'h00204, 32'h5555_0001, 2'd1, 20'h00200,
      {32'h3333_0003, 32'h3333_0002, 32'h5555_0001, 32'h5555_0000}},
    // R4: SRAM word index 2, high dword first
    {4'd4, 20'h80014, 32'h6666_0001, 2'd0, 20'h0, 128'h0},
    {4'd4, 20'h80010, 32'h6666_0000, 2'd2, 20'h00002,
      {64'h0, 32'h6666_0001, 32'h6666_0000}},
    // R5/R10: top dword alone in page 1
    {4'd5, 20'h0283C, 32'h7777_0003, 2'd1, 20'h02830,
      {32'h7777_0003, 96'h0}},
    // R5/R10: page 2 pointer with dword1 gathered
    {4'd10, 20'h04A14, 32'h8888_0001, 2'd0, 20'h0, 128'h0},
    {4'd10, 20'h04A1C, 32'h8888_0003, 2'd1, 20'h04A10,
      {32'h8888_0003, 32'h0, 32'h8888_0001, 32'h0}},
    // R6: stray pointer lower dword dropped, 0x500 survives
    {4'd6, 20'h00500, 32'h9999_0000, 2'd0, 20'h0, 128'h0},
    {4'd6, 20'h00834, 32'hDEAD_0001, 2'd0, 20'h0, 128'h0},
    {4'd6, 20'h00504, 32'h9999_0001, 2'd0, 20'h0, 128'h0},
    {4'd6, 20'h00508, 32'h9999_0002, 2'd0, 20'h0, 128'h0},
    {4'd6, 20'h0050C, 32'h9999_0003, 2'd1, 20'h00500,
      {32'h9999_0003, 32'h9999_0002, 32'h9999_0001, 32'h9999_0000}},
    // R7: narrow register page 3
    {4'd7, 20'h06400, 32'hAAAA_0000, 2'd3, 20'h06400, {96'h0, 32'hAAAA_0000}},
    // R8: 0x420 page 0 clears partial 0x600
    {4'd8, 20'h00600, 32'hBBBB_0000, 2'd0, 20'h0, 128'h0},
    {4'd8, 20'h00604, 32'hBBBB_0001, 2'd0, 20'h0, 128'h0},
    {4'd8, 20'h00608, 32'hBBBB_0002, 2'd0, 20'h0, 128'h0},
    {4'd8, 20'h00420, 32'hCCCC_0000, 2'd3, 20'h00420, {96'h0, 32'hCCCC_0000}},
    {4'd8, 20'h0060C, 32'hBBBB_0003, 2'd0, 20'h0, 128'h0},
    {4'd8, 20'h00600, 32'hDDDD_0000, 2'd0, 20'h0, 128'h0},
    {4'd8, 20'h00604, 32'hDDDD_0001, 2'd0, 20'h0, 128'h0},
    {4'd8, 20'h00608, 32'hDDDD_0002, 2'd1, 20'h00600,
      {32'hBBBB_0003, 32'hDDDD_0002, 32'hDDDD_0001, 32'hDDDD_0000}},
    // R7: 0x420 in page 3 keeps partial 0x700
    {4'd7, 20'h00700, 32'hEEEE_0000, 2'd0, 20'h0, 128'h0},
    {4'd7, 20'h06420, 32'hCCCC_0003, 2'd3, 20'h06420, {96'h0, 32'hCCCC_0003}},
    {4'd7, 20'h00704, 32'hEEEE_0001, 2'd0, 20'h0, 128'h0},
    {4'd7, 20'h00708, 32'hEEEE_0002, 2'd0, 20'h0, 128'h0},
    {4'd7, 20'h0070C, 32'hEEEE_0003, 2'd1, 20'h00700,
      {32'hEEEE_0003, 32'hEEEE_0002, 32'hEEEE_0001, 32'hEEEE_0000}},
    // R5: pointer top while collector holds 0x800; 0x800 survives
    {4'd5, 20'h00800, 32'hF0F0_0000, 2'd0, 20'h0, 128'h0},
    {4'd5, 20'h00A1C, 32'hF1F1_0003, 2'd1, 20'h00A10, {32'hF1F1_0003, 96'h0}},
    {4'd5, 20'h00804, 32'hF0F0_0001, 2'd0, 20'h0, 128'h0},
    {4'd5, 20'h00808, 32'hF0F0_0002, 2'd0, 20'h0, 128'h0},
    {4'd5, 20'h0080C, 32'hF0F0_0003, 2'd1, 20'h00800,
      {32'hF0F0_0003, 32'hF0F0_0002, 32'hF0F0_0001, 32'hF0F0_0000}}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              host_valid = 1'b0;
  logic [ADDR_W-1:0] host_addr = '0;
  logic [31:0]       host_data = '0;
  logic              reg_wr_en;
  logic [ADDR_W-1:0] reg_wr_addr;
  logic [127:0]      reg_wr_data;
  logic              sram_wr_en;
  logic [SIDX_W-1:0] sram_wr_idx;
  logic [63:0]       sram_wr_data;
  logic              dw_wr_en;
  logic [ADDR_W-1:0] dw_wr_addr;
  logic [31:0]       dw_wr_data;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wide_write_collector u_wide_write_collector (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_addr(host_addr),
    .host_data(host_data), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .sram_wr_en(sram_wr_en), .sram_wr_idx(sram_wr_idx),
    .sram_wr_data(sram_wr_data), .dw_wr_en(dw_wr_en), .dw_wr_addr(dw_wr_addr),
    .dw_wr_data(dw_wr_data)
  );

  task automatic check_ports(input logic [1:0] kind, input logic [19:0] ea,
                             input logic [127:0] ed, input string req);
    logic [1:0]   got_kind;
    logic [19:0]  got_a;
    logic [127:0] got_d;
    got_kind = 2'd0; got_a = '0; got_d = '0;
    if (reg_wr_en) begin got_kind = 2'd1; got_a = reg_wr_addr; got_d = reg_wr_data; end
    if (sram_wr_en) begin
      got_kind = (got_kind != 0) ? 2'd0 : 2'd2;
      got_a = 20'(sram_wr_idx); got_d = {64'h0, sram_wr_data};
    end
    if (dw_wr_en) begin
      got_kind = (got_kind != 0) ? 2'd0 : 2'd3;
      got_a = dw_wr_addr; got_d = {96'h0, dw_wr_data};
    end
    compared++;
    if ({reg_wr_en, sram_wr_en, dw_wr_en} != ((kind == 0) ? 3'b000 : (3'b100 >> (kind - 1))) ||
        (kind != 0 && (got_a != ea || got_d != ed))) begin
      mismatched++;
      $display("FAIL %s: strobes=%b kind=%0d addr=%h data=%h expected kind=%0d addr=%h data=%h",
               req, {reg_wr_en, sram_wr_en, dw_wr_en}, got_kind, got_a, got_d, kind, ea, ed);
    end
  endtask

  task automatic do_write(input logic [19:0] a, input logic [31:0] d);
    @(negedge clk);
    host_valid = 1'b1; host_addr = a; host_data = d;
    @(negedge clk);
    host_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    finish_run();
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    check_ports(2'd0, '0, '0, "R9 reset strobes");
    rst_n = 1'b1;
    @(negedge clk);
    check_ports(2'd0, '0, '0, "R9 idle after reset");

    for (int i = 0; i < NV; i++) begin
      logic [ENT_W-1:0] e;
      e = VEC[i];
      do_write(e[201:182], e[181:150]);
      check_ports(e[149:148], e[147:128], e[127:0], $sformatf("R%0d vec %0d", e[205:202], i));
    end

    // R1/R9: four beats back to back, strobe one cycle after the last, for one cycle
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      host_valid = 1'b1; host_addr = 20'h00900 + 20'(4 * k); host_data = 32'h1234_0000 + k;
      @(negedge clk);
      if (k < 3) check_ports(2'd0, '0, '0, "R1 burst partial");
    end
    host_valid = 1'b0;
    check_ports(2'd1, 20'h00900, {32'h1234_0003, 32'h1234_0002, 32'h1234_0001, 32'h1234_0000},
                "R1 burst commit");
    @(negedge clk);
    check_ports(2'd0, '0, '0, "R9 strobe single cycle");

    // R9: reset mid-collection discards gathered dwords
    do_write(20'h00B00, 32'h5A5A_0000);
    do_write(20'h00B04, 32'h5A5A_0001);
    do_write(20'h00B08, 32'h5A5A_0002);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    do_write(20'h00B0C, 32'h5A5A_0003);
    check_ports(2'd0, '0, '0, "R9 reset empties collector");
    do_write(20'h00B00, 32'h6B6B_0000);
    do_write(20'h00B04, 32'h6B6B_0001);
    do_write(20'h00B08, 32'h6B6B_0002);
    check_ports(2'd1, 20'h00B00, {32'h5A5A_0003, 32'h6B6B_0002, 32'h6B6B_0001, 32'h6B6B_0000},
                "R9 collection after reset");

    // R4: SRAM word at the top of the test range, low dword first
    do_write(20'h80FF8, 32'h0C0C_0000);
    do_write(20'h80FFC, 32'h0C0C_0001);
    check_ports(2'd2, 20'h001FF, {64'h0, 32'h0C0C_0001, 32'h0C0C_0000}, "R4 sram low first");

    finish_run();
  end
endmodule